// File: doc/BRIEF.md
# Two-Bit PQ Interrupt Source Controller

This block gates one interrupt source with a two-bit state, P and Q. P means a notification has gone out toward the interrupt router and has not yet been retired. Q means a further event arrived while P was set. An event seen with P clear sets P and sends one notification pulse. An event seen with P set is recorded in Q. The state P=0, Q=1 is the masked state, and events there are dropped.

Software reaches the state through an offset-decoded access window. Loads at four offsets force PQ to each of its four values and return the value held before. One load offset only reads the state. A load-side end-of-interrupt serves level sources, a store-side end-of-interrupt serves both kinds, and a store at offset zero injects an event. Masking, unmasking, retrigger and end-of-interrupt are all built from these atomic accesses. An errata mode repairs offsets from drivers that place the selector four bits too low.

Top module: `pq_source_ctrl`

## Requirements
- R1: After reset the state is PQ=01 (masked) and `notify` is low; a state read then returns 01.
- R2: A load at offset 0x800 returns the current state in `rd_data` one cycle later and leaves the state unchanged. Bit 1 holds P, bit 0 holds Q, and every other bit is zero.
- R3: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 set PQ to 00, 01, 10 and 11 respectively. Each returns the state held before the access.
- R4: In edge mode, an event comes from a `trig_in` pulse or from a store at offset 0x000. With PQ=00 an event gives PQ=10 and a one-cycle `notify` pulse on the next cycle. With P=1 an event sets Q and emits nothing. With PQ=01 an event leaves the state unchanged and emits nothing.
- R5: A load at offset 0x000 returns the old state and clears PQ to 00. In level mode, if `lvl_in` is still high, it sets P again and pulses `notify`. In edge mode it never notifies, and software learns of a lost event from the returned Q.
- R6: A store at offset 0x400 clears PQ to 00 and returns no data. It then re-notifies, giving PQ=10 and a pulse, when the old Q was 1 in edge mode, or when `lvl_in` is high in level mode.
- R7: In level mode, `lvl_in` high with PQ=00 gives PQ=10 and one pulse. While P=1, a held `lvl_in` changes nothing, and `trig_in` and trigger stores are ignored.
- R8: With `errata_en` high, the offset is ORed with itself shifted left by 4 before decoding. For example, 0x0F0 acts as 0xFF0 (set 11) and 0x080 acts as 0x880 (state read).
- R9: A retrigger, made of a load setting PQ=11 followed by a store end-of-interrupt, produces one `notify` pulse and leaves PQ=10.
- R10: When an access and an event fall in the same cycle, the access is applied first and the event acts on the result. At most one pulse is emitted, and the read returns the state from before both.
- R11: A load at an unmapped offset returns zero and changes nothing. A store at an unmapped offset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_mode | input | 1 | 1 = level-sensitive source, 0 = message/edge source |
| errata_en | input | 1 | Enables offset repair by OR with offset shifted left 4 |
| trig_in | input | 1 | Edge event pulse from the source |
| lvl_in | input | 1 | Level input used in level mode |
| acc_valid | input | 1 | Window access strobe |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_ofs | input | OFS_W | Access offset |
| rd_valid | output | 1 | Load result valid, one cycle after the load |
| rd_data | output | DATA_W | Load result: P in bit 1, Q in bit 0 |
| notify | output | 1 | One-cycle notification pulse toward the router |

## Verification
A window access and a source event can land in the same cycle. The case that matters is an end-of-interrupt arriving together with a fresh trigger, because the end-of-interrupt's own re-notify and the new event then compete for P. The bench provokes this by raising `trig_in` in the same cycle as a store end-of-interrupt while Q is set, and again with a set-to-00 load on a masked source. It judges the result by a single `notify` pulse, the returned old state, and a later state read showing the event landed in Q or P as the access-first ordering demands.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;

    typedef struct packed {
        logic p;
        logic q;
    } pq_t;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_GET,
        OP_SET00,
        OP_SET01,
        OP_SET10,
        OP_SET11,
        OP_LD_EOI,
        OP_ST_EOI,
        OP_TRIG,
        OP_BAD_RD
    } pq_op_e;

    localparam int SEL_W = 4;

    localparam logic [SEL_W-1:0] SEL_EOI_TRIG = 4'h0;
    localparam logic [SEL_W-1:0] SEL_ST_EOI   = 4'h4;
    localparam logic [SEL_W-1:0] SEL_GET      = 4'h8;
    localparam logic [SEL_W-1:0] SEL_SET00    = 4'hC;
    localparam logic [SEL_W-1:0] SEL_SET01    = 4'hD;
    localparam logic [SEL_W-1:0] SEL_SET10    = 4'hE;
    localparam logic [SEL_W-1:0] SEL_SET11    = 4'hF;

    typedef struct packed {
        pq_t        pq;
        logic       notify;
        logic       rd_valid;
        logic [1:0] rd_pq;
    } pq_regs_t;

    function automatic logic is_load_op(input pq_op_e op);
        return (op == OP_GET) || (op == OP_SET00) || (op == OP_SET01) ||
               (op == OP_SET10) || (op == OP_SET11) || (op == OP_LD_EOI);
    endfunction

endpackage

// File: rtl/pq_src_decode.sv
module pq_src_decode
    import pq_src_pkg::*;
#(
    parameter int OFS_W        = 12,
    parameter int ERRATA_SHIFT = 4
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [OFS_W-1:0] acc_ofs,
    input  logic             errata_en,
    output pq_op_e           op
);
    localparam int SEL_LSB = OFS_W - SEL_W;
    localparam logic [OFS_W-1:0] SEL_MASK = {{SEL_W{1'b1}}, {SEL_LSB{1'b0}}};

    logic [OFS_W-1:0] ofs_fixed;
    logic [SEL_W-1:0] sel;

    always_comb begin
        ofs_fixed = errata_en ? (acc_ofs | (acc_ofs << ERRATA_SHIFT)) : acc_ofs;
    end

    // Only the selector field decides; the low bits fall away in the mask.
    always_comb begin
        logic [OFS_W-1:0] masked;
        masked = (ofs_fixed & SEL_MASK) >> SEL_LSB;
        sel    = masked[SEL_W-1:0];
    end

    always_comb begin
        op = OP_NONE;
        if (acc_valid) begin
            if (acc_write) begin
                unique case (sel)
                    SEL_EOI_TRIG: op = OP_TRIG;
                    SEL_ST_EOI:   op = OP_ST_EOI;
                    default:      op = OP_NONE;
                endcase
            end else begin
                unique case (sel)
                    SEL_EOI_TRIG: op = OP_LD_EOI;
                    SEL_GET:      op = OP_GET;
                    SEL_SET00:    op = OP_SET00;
                    SEL_SET01:    op = OP_SET01;
                    SEL_SET10:    op = OP_SET10;
                    SEL_SET11:    op = OP_SET11;
                    default:      op = OP_BAD_RD;
                endcase
            end
        end
    end

endmodule

// File: rtl/pq_src_trig.sv
module pq_src_trig
    import pq_src_pkg::*;
(
    input  logic   level_mode,
    input  logic   trig_in,
    input  logic   lvl_in,
    input  pq_op_e op,
    output logic   edge_evt,
    output logic   lvl_evt
);
    always_comb begin
        edge_evt = !level_mode && (trig_in || (op == OP_TRIG));
        lvl_evt  = level_mode && lvl_in;
    end
endmodule

// File: rtl/pq_src_next.sv
module pq_src_next
    import pq_src_pkg::*;
(
    input  pq_t    pq_old,
    input  pq_op_e op,
    input  logic   level_mode,
    input  logic   lvl_in,
    input  logic   edge_evt,
    input  logic   lvl_evt,
    output pq_t    pq_new,
    output logic   notify_new
);
    pq_t  pq_acc;
    logic renotify;

    // Step 1: the access rewrites the state.
    always_comb begin
        pq_acc   = pq_old;
        renotify = 1'b0;
        unique case (op)
            OP_SET00:  pq_acc = 2'b00;
            OP_SET01:  pq_acc = 2'b01;
            OP_SET10:  pq_acc = 2'b10;
            OP_SET11:  pq_acc = 2'b11;
            OP_LD_EOI: begin
                pq_acc   = 2'b00;
                renotify = level_mode && lvl_in;
            end
            OP_ST_EOI: begin
                pq_acc   = 2'b00;
                renotify = level_mode ? lvl_in : pq_old.q;
            end
            default: ;
        endcase
        if (renotify) pq_acc = 2'b10;
    end

    // Step 2: the source event acts on the post-access state.
    always_comb begin
        pq_new     = pq_acc;
        notify_new = renotify;
        if (edge_evt) begin
            if (pq_acc == 2'b00) begin
                pq_new     = 2'b10;
                notify_new = 1'b1;
            end else if (pq_acc.p) begin
                pq_new.q = 1'b1;
            end
        end else if (lvl_evt && (pq_acc == 2'b00)) begin
            pq_new     = 2'b10;
            notify_new = 1'b1;
        end
    end

endmodule

// File: rtl/pq_source_ctrl.sv
module pq_source_ctrl
    import pq_src_pkg::*;
#(
    parameter int OFS_W        = 12,
    parameter int DATA_W       = 64,
    parameter int ERRATA_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_mode,
    input  logic              errata_en,
    input  logic              trig_in,
    input  logic              lvl_in,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_ofs,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              notify
);
    localparam pq_regs_t REGS_RST = '{pq: 2'b01, notify: 1'b0, rd_valid: 1'b0, rd_pq: 2'b00};

    pq_op_e   op;
    logic     edge_evt;
    logic     lvl_evt;
    pq_t      pq_new;
    logic     notify_new;
    pq_regs_t regs_d, regs_q;

    pq_src_decode #(.OFS_W(OFS_W), .ERRATA_SHIFT(ERRATA_SHIFT)) u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_ofs   (acc_ofs),
        .errata_en (errata_en),
        .op        (op)
    );

    pq_src_trig u_trig (
        .level_mode (level_mode),
        .trig_in    (trig_in),
        .lvl_in     (lvl_in),
        .op         (op),
        .edge_evt   (edge_evt),
        .lvl_evt    (lvl_evt)
    );

    pq_src_next u_next (
        .pq_old     (regs_q.pq),
        .op         (op),
        .level_mode (level_mode),
        .lvl_in     (lvl_in),
        .edge_evt   (edge_evt),
        .lvl_evt    (lvl_evt),
        .pq_new     (pq_new),
        .notify_new (notify_new)
    );

    always_comb begin
        regs_d          = regs_q;
        regs_d.pq       = pq_new;
        regs_d.notify   = notify_new;
        regs_d.rd_valid = acc_valid && !acc_write;
        regs_d.rd_pq    = is_load_op(op) ? regs_q.pq : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign rd_valid = regs_q.rd_valid;
    assign rd_data  = DATA_W'(regs_q.rd_pq);
    assign notify   = regs_q.notify;

    // R3 / R2: a load reports the state held before it.
    p_rd_old_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load_op(op)) |=> (rd_data[1:0] == $past(regs_q.pq)));

    // R2: a state read with no event keeps the state.
    p_get_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_GET && !edge_evt && !lvl_evt) |=> $stable(regs_q.pq));

    // R4: a pulse is always accompanied by P set.
    p_notify_p_r4: assert property (@(posedge clk) disable iff (!rst_n)
        notify |-> regs_q.pq.p);

    // R4: a masked source stays silent when nothing rewrites it.
    p_masked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.pq == 2'b01 && (op == OP_NONE || op == OP_GET || op == OP_TRIG))
        |=> (!notify && regs_q.pq == 2'b01));

    // R3: forcing 11 always lands on 11.
    p_set11_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SET11) |=> (regs_q.pq == 2'b11));

    // R11: an unmapped load returns zero.
    p_bad_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_BAD_RD) |=> (rd_valid && rd_data == '0));

endmodule

// File: tb/pq_source_ctrl_bench.sv
module pq_source_ctrl_bench;
    localparam int OFS_W  = 12;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              level_mode = 1'b0;
    logic              errata_en = 1'b0;
    logic              trig_in = 1'b0;
    logic              lvl_in = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic [OFS_W-1:0]  acc_ofs = '0;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              notify;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    pq_source_ctrl #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_pq_source_ctrl (
        .clk, .rst_n, .level_mode, .errata_en, .trig_in, .lvl_in,
        .acc_valid, .acc_write, .acc_ofs, .rd_valid, .rd_data, .notify
    );

    // Monitor: pops the scoreboard on every returned load.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected read: got %h expected none", rd_data);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== DATA_W'(e)) begin
                    errors++;
                    $display("FAIL %s read: got %h expected %h", t, rd_data, DATA_W'(e));
                end
            end
        end
    end

    // Driver: one access (optionally with a trigger) for one cycle.
    task automatic acc(input logic wr, input logic [OFS_W-1:0] ofs, input logic trg,
                       input logic [1:0] exp, input string tag);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = wr; acc_ofs = ofs; trig_in = trg;
        if (!wr) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; trig_in = 1'b0;
    endtask

    task automatic pulse_trig();
        @(posedge clk); #1; trig_in = 1'b1;
        @(posedge clk); #1; trig_in = 1'b0;
    endtask

    task automatic get(input logic [1:0] exp, input string tag);
        acc(1'b0, 12'h800, 1'b0, exp, tag);
    endtask

    task automatic chk_notify(input logic exp, input string tag);
        checks++;
        if (notify !== exp) begin
            errors++;
            $display("FAIL %s notify: got %b expected %b", tag, notify, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_notify(1'b0, "R1");
        get(2'b01, "R1");
        // R4 masked source drops events
        pulse_trig();
        chk_notify(1'b0, "R4 masked");
        get(2'b01, "R4 masked");
        // R3 unmask to 00
        acc(1'b0, 12'hC00, 1'b0, 2'b01, "R3 set00");
        get(2'b00, "R3");
        // R4 first event notifies, second sets Q
        pulse_trig();
        chk_notify(1'b1, "R4 first");
        get(2'b10, "R4");
        chk_notify(1'b0, "R4 single pulse");
        pulse_trig();
        chk_notify(1'b0, "R4 second");
        get(2'b11, "R4 Q set");
        // R5 edge end-of-interrupt via set00 returns Q=1, no resend
        acc(1'b0, 12'hC00, 1'b0, 2'b11, "R5 edge eoi");
        chk_notify(1'b0, "R5 edge no resend");
        get(2'b00, "R5");
        // R4 trigger store
        acc(1'b1, 12'h000, 1'b0, 2'b00, "R4 trig store");
        chk_notify(1'b1, "R4 trig store");
        get(2'b10, "R4 trig store");
        // R6 store eoi, old Q=0
        acc(1'b1, 12'h400, 1'b0, 2'b00, "R6");
        chk_notify(1'b0, "R6 no Q");
        get(2'b00, "R6");
        // R6 store eoi with old Q=1 reissues
        pulse_trig();
        pulse_trig();
        acc(1'b1, 12'h400, 1'b0, 2'b00, "R6");
        chk_notify(1'b1, "R6 reissue");
        get(2'b10, "R6 reissue");
        // R9 retrigger
        acc(1'b0, 12'hF00, 1'b0, 2'b10, "R9 set11");
        acc(1'b1, 12'h400, 1'b0, 2'b00, "R9");
        chk_notify(1'b1, "R9 retrigger");
        get(2'b10, "R9");
        // R3 mask, event dropped
        acc(1'b0, 12'hD00, 1'b0, 2'b10, "R3 set01");
        pulse_trig();
        chk_notify(1'b0, "R3 masked");
        get(2'b01, "R3 masked");
        // R3 unmask with pending, event goes to Q
        acc(1'b0, 12'hE00, 1'b0, 2'b01, "R3 set10");
        pulse_trig();
        chk_notify(1'b0, "R4 pending");
        get(2'b11, "R3 set10");
        // R11 unmapped accesses
        acc(1'b0, 12'h200, 1'b0, 2'b00, "R11 load");
        acc(1'b1, 12'h600, 1'b0, 2'b00, "R11 store");
        get(2'b11, "R11 unchanged");
        // R5 load eoi in edge mode: old state returned, no notify
        acc(1'b0, 12'h000, 1'b0, 2'b11, "R5 load eoi");
        chk_notify(1'b0, "R5 edge load eoi");
        get(2'b00, "R5");
        // R8 errata offset repair
        errata_en = 1'b1;
        acc(1'b0, 12'h0F0, 1'b0, 2'b00, "R8 set11");
        acc(1'b0, 12'h080, 1'b0, 2'b11, "R8 get");
        errata_en = 1'b0;
        // R7 level mode
        level_mode = 1'b1;
        acc(1'b0, 12'hC00, 1'b0, 2'b11, "R7 set00");
        @(posedge clk); #1 lvl_in = 1'b1;
        @(posedge clk); #1 chk_notify(1'b1, "R7 level notify");
        @(posedge clk); #1 chk_notify(1'b0, "R7 level held");
        pulse_trig();
        chk_notify(1'b0, "R7 trig ignored");
        get(2'b10, "R7 no Q");
        // R5 level load eoi with input high renotifies
        acc(1'b0, 12'h000, 1'b0, 2'b10, "R5 level eoi");
        chk_notify(1'b1, "R5 level renotify");
        get(2'b10, "R5 level");
        lvl_in = 1'b0;
        acc(1'b0, 12'h000, 1'b0, 2'b10, "R5 level eoi low");
        chk_notify(1'b0, "R5 level low");
        get(2'b00, "R5 level low");
        level_mode = 1'b0;
        // R10 store eoi plus event in the same cycle
        acc(1'b0, 12'hF00, 1'b0, 2'b00, "R10 set11");
        acc(1'b1, 12'h400, 1'b1, 2'b00, "R10");
        chk_notify(1'b1, "R10 eoi+trig");
        get(2'b11, "R10 event to Q");
        // R10 set00 plus event on a masked source
        acc(1'b0, 12'hD00, 1'b0, 2'b11, "R10 set01");
        acc(1'b0, 12'hC00, 1'b1, 2'b01, "R10 set00+trig");
        chk_notify(1'b1, "R10 unmask+trig");
        get(2'b10, "R10");
        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 scoreboard: got %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule